// File: doc/BRIEF.md
# PLL Holdover Controller

This block decides, one clock at a time, whether the loop's charge pump drives the loop filter or is parked in high impedance (holdover). It watches the digital lock flag and, when enabled, a lock comparator flag from an external pin. It also takes a per-phase-detector-cycle strobe that says whether the currently selected reference produced an edge, and a flag that marks a reference switchover in progress. Holdover is either requested from outside (external mode) or raised internally when lock is lost and the reference edge goes missing.

Leaving holdover is a two-step affair. The controller first waits in an exit-alignment state until the next reference-path phase-detector event. It then releases the charge pump and, on that same edge, issues a single-cycle reset to the feedback B counter; the prescaler is left alone. After that, the controller sits in a re-arm state and refuses new holdover until lock has been seen again and the comparator flag is high. The reference edge strobe is always taken from whichever reference is currently selected upstream.

All pins are plain control and status levels with no data stream, so there is no valid/ready handshake and no back-pressure. Every input is sampled on the rising clock edge. Both outputs come from registers.

Top module: `pll_holdover_ctrl`

## Requirements
- R1: A synchronous active-high reset puts the controller in the re-arm state, with cp_hiz_o = 0 and fb_div_rst_o = 0.
- R2: Holdover is entered only if hold_en_a_i and hold_en_b_i are both 1. With either bit at 0, cp_hiz_o stays 0 in every mode.
- R3: When cmp_en_i = 0, lock_cmp_i is ignored and treated as 1.
- R4: From the re-arm state, the controller arms only when the comparator flag is high (per R3) and, in internal mode, lock_det_en_i = 1 and lock_ok_i = 1. External mode needs the comparator flag only. No holdover entry is possible before arming.
- R5: In internal mode (ext_mode_i = 0), an armed controller enters holdover on a clock where pfd_tick_i = 1, ref_edge_i = 0, lock_ok_i = 0 and lock_det_en_i = 1. cp_hiz_o rises one clock later.
- R6: With lock_det_en_i = 0, internal-mode entry never happens.
- R7: While swo_busy_i = 1, loss of lock on a tick enters holdover even if ref_edge_i = 1. In internal mode, holdover ends on the next tick that carries ref_edge_i = 1.
- R8: In external mode (ext_mode_i = 1), an armed controller enters holdover while ext_req_i = 1 and leaves it when ext_req_i returns to 0.
- R9: After holdover ends, cp_hiz_o stays 1 until a clock with pfd_tick_i = 1 and ref_edge_i = 1. One clock later, cp_hiz_o falls and fb_div_rst_o is 1 for exactly that one clock. fb_div_rst_o is never 1 at any other time.
- R10: Clearing either enable bit during holdover ends it and starts the exit alignment of R9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| lock_ok_i | input | 1 | Digital lock detector reports lock |
| lock_det_en_i | input | 1 | Digital lock detector enabled |
| lock_cmp_i | input | 1 | Lock comparator flag from pin |
| cmp_en_i | input | 1 | Use the comparator flag (0: treat as high) |
| pfd_tick_i | input | 1 | One phase-detector cycle completed this clock |
| ref_edge_i | input | 1 | Selected reference produced an edge in that cycle |
| swo_busy_i | input | 1 | Reference switchover in progress |
| hold_en_a_i | input | 1 | Holdover enable, first bit |
| hold_en_b_i | input | 1 | Holdover enable, second bit |
| ext_mode_i | input | 1 | 1: external request drives holdover; 0: internal monitoring |
| ext_req_i | input | 1 | External holdover request |
| cp_hiz_o | output | 1 | Charge pump in high impedance (holdover) |
| fb_div_rst_o | output | 1 | One-clock synchronous reset of the feedback B counter |

## Verification
Directed sequences first walk through internal loss of lock with a missing edge, a tick that carries an edge, switchover with lock lost, and external request and release. These separate the internal and external entry paths and show the exit alignment waiting for a real reference event. Further directed patterns clear one enable bit, disable the lock detector, and hold the comparator low with and without its enable. These show that entry is blocked and that arming depends on the comparator. A long random phase then varies the tick density, the edge presence and the configuration, against a behavioural model compared on every clock. This exposes ordering faults such as a B counter reset that comes out of step with the charge pump release.

// File: rtl/holdover_pkg.sv
package holdover_pkg;
  typedef enum logic [1:0] {
    HS_REARM  = 2'd0,
    HS_LOCKED = 2'd1,
    HS_HOLD   = 2'd2,
    HS_ALIGN  = 2'd3
  } hold_state_e;
endpackage

// File: rtl/hold_qualify.sv
module hold_qualify (
  input  logic lock_ok_i,
  input  logic lock_det_en_i,
  input  logic lock_cmp_i,
  input  logic cmp_en_i,
  input  logic pfd_tick_i,
  input  logic ref_edge_i,
  input  logic swo_busy_i,
  input  logic hold_en_a_i,
  input  logic hold_en_b_i,
  input  logic ext_mode_i,
  input  logic ext_req_i,
  output logic rearm_ok_o,
  output logic enter_o,
  output logic leave_o,
  output logic align_evt_o
);
  logic pin_high;
  logic hold_en;
  logic ref_event;
  logic lock_lost;
  logic int_enter;
  logic int_leave;

  // comparator flag counts as high when the comparator is not used
  assign pin_high  = cmp_en_i ? lock_cmp_i : 1'b1;
  assign hold_en   = hold_en_a_i & hold_en_b_i;
  assign ref_event = pfd_tick_i & ref_edge_i;
  assign lock_lost = lock_det_en_i & ~lock_ok_i;

  // internal path: a tick without an edge, or any tick while switching references
  assign int_enter = lock_lost & pfd_tick_i & (~ref_edge_i | swo_busy_i);
  assign int_leave = ref_event;

  always_comb begin
    rearm_ok_o  = pin_high & (ext_mode_i | (lock_det_en_i & lock_ok_i));
    enter_o     = hold_en & (ext_mode_i ? ext_req_i : int_enter);
    leave_o     = ~hold_en | (ext_mode_i ? ~ext_req_i : int_leave);
    align_evt_o = ref_event;
  end
endmodule

// File: rtl/hold_fsm.sv
module hold_fsm
  import holdover_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        rearm_ok_i,
  input  logic        enter_i,
  input  logic        leave_i,
  input  logic        align_evt_i,
  output hold_state_e state_o,
  output logic        release_o
);
  hold_state_e state_q;
  hold_state_e state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      HS_REARM:  if (rearm_ok_i)  state_d = HS_LOCKED;
      HS_LOCKED: if (enter_i)     state_d = HS_HOLD;
      HS_HOLD:   if (leave_i)     state_d = HS_ALIGN;
      HS_ALIGN:  if (align_evt_i) state_d = HS_REARM;
      default:                    state_d = HS_REARM;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= HS_REARM;
    else     state_q <= state_d;
  end

  assign state_o   = state_q;
  assign release_o = (state_q == HS_ALIGN) & align_evt_i;

  AST_REARM_BLOCKS_HOLD: assert property (@(posedge clk) disable iff (rst)
    (state_q == HS_REARM) |=> (state_q != HS_HOLD)); // R4
  AST_HOLD_FROM_LOCKED: assert property (@(posedge clk) disable iff (rst)
    $rose(state_q == HS_HOLD) |-> ($past(state_q) == HS_LOCKED)); // R2
  AST_ALIGN_WAITS_EDGE: assert property (@(posedge clk) disable iff (rst)
    ((state_q == HS_ALIGN) && !align_evt_i) |=> (state_q == HS_ALIGN)); // R9
  AST_LOCKED_STAYS: assert property (@(posedge clk) disable iff (rst)
    ((state_q == HS_LOCKED) && !enter_i) |=> (state_q == HS_LOCKED)); // R5
endmodule

// File: rtl/edge_pulse.sv
module edge_pulse (
  input  logic clk,
  input  logic rst,
  input  logic fire_i,
  output logic pulse_o
);
  logic pulse_q;

  always_ff @(posedge clk) begin
    if (rst) pulse_q <= 1'b0;
    else     pulse_q <= fire_i;
  end

  assign pulse_o = pulse_q;

  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    pulse_q |=> !pulse_q); // R9
endmodule

// File: rtl/pll_holdover_ctrl.sv
module pll_holdover_ctrl
  import holdover_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic lock_ok_i,
  input  logic lock_det_en_i,
  input  logic lock_cmp_i,
  input  logic cmp_en_i,
  input  logic pfd_tick_i,
  input  logic ref_edge_i,
  input  logic swo_busy_i,
  input  logic hold_en_a_i,
  input  logic hold_en_b_i,
  input  logic ext_mode_i,
  input  logic ext_req_i,
  output logic cp_hiz_o,
  output logic fb_div_rst_o
);
  logic        rearm_ok;
  logic        enter_req;
  logic        leave_req;
  logic        align_evt;
  logic        release_now;
  hold_state_e state;

  hold_qualify u_qual (
    .lock_ok_i     (lock_ok_i),
    .lock_det_en_i (lock_det_en_i),
    .lock_cmp_i    (lock_cmp_i),
    .cmp_en_i      (cmp_en_i),
    .pfd_tick_i    (pfd_tick_i),
    .ref_edge_i    (ref_edge_i),
    .swo_busy_i    (swo_busy_i),
    .hold_en_a_i   (hold_en_a_i),
    .hold_en_b_i   (hold_en_b_i),
    .ext_mode_i    (ext_mode_i),
    .ext_req_i     (ext_req_i),
    .rearm_ok_o    (rearm_ok),
    .enter_o       (enter_req),
    .leave_o       (leave_req),
    .align_evt_o   (align_evt)
  );

  hold_fsm u_fsm (
    .clk         (clk),
    .rst         (rst),
    .rearm_ok_i  (rearm_ok),
    .enter_i     (enter_req),
    .leave_i     (leave_req),
    .align_evt_i (align_evt),
    .state_o     (state),
    .release_o   (release_now)
  );

  // the B counter reset register loads on the same edge the state leaves alignment,
  // so it rises exactly when the charge pump leaves high impedance
  edge_pulse u_brst (
    .clk     (clk),
    .rst     (rst),
    .fire_i  (release_now),
    .pulse_o (fb_div_rst_o)
  );

  assign cp_hiz_o = (state == HS_HOLD) || (state == HS_ALIGN);

  AST_NO_ENTRY_DISABLED: assert property (@(posedge clk) disable iff (rst)
    (!cp_hiz_o && !(hold_en_a_i && hold_en_b_i)) |=> !cp_hiz_o); // R2
  AST_NO_AUTO_WITHOUT_DET: assert property (@(posedge clk) disable iff (rst)
    (!cp_hiz_o && !ext_mode_i && !lock_det_en_i) |=> !cp_hiz_o); // R6
  AST_BRST_WITH_RELEASE: assert property (@(posedge clk) disable iff (rst)
    fb_div_rst_o |-> (!cp_hiz_o && $past(cp_hiz_o))); // R9
  AST_HOLD_NEEDS_TICK_OR_EXT: assert property (@(posedge clk) disable iff (rst)
    ($rose(cp_hiz_o) && !$past(ext_mode_i)) |-> $past(pfd_tick_i)); // R5
endmodule

// File: tb/pll_holdover_ctrl_tb_top.sv
`timescale 1ns/1ps
module pll_holdover_ctrl_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic lock_ok = 1'b0, lock_det_en = 1'b1, lock_cmp = 1'b0, cmp_en = 1'b1;
  logic pfd_tick = 1'b0, ref_edge = 1'b0, swo_busy = 1'b0;
  logic en_a = 1'b1, en_b = 1'b1, ext_mode = 1'b0, ext_req = 1'b0;
  logic cp_hiz, fb_rst;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  // behavioural model: 0 re-arm, 1 armed, 2 holdover, 3 exit alignment
  int    m_st = 0;
  bit    exp_cp = 1'b0;
  bit    exp_br = 1'b0;
  string tag = "R1";

  always #4 clk = ~clk;

  pll_holdover_ctrl dut_i (
    .clk(clk), .rst(rst),
    .lock_ok_i(lock_ok), .lock_det_en_i(lock_det_en),
    .lock_cmp_i(lock_cmp), .cmp_en_i(cmp_en),
    .pfd_tick_i(pfd_tick), .ref_edge_i(ref_edge), .swo_busy_i(swo_busy),
    .hold_en_a_i(en_a), .hold_en_b_i(en_b),
    .ext_mode_i(ext_mode), .ext_req_i(ext_req),
    .cp_hiz_o(cp_hiz), .fb_div_rst_o(fb_rst)
  );

  task automatic model_step();
    bit pin_ok, en, evt;
    pin_ok = cmp_en ? lock_cmp : 1'b1;
    en     = en_a && en_b;
    evt    = pfd_tick && ref_edge;
    exp_br = 1'b0;
    if (rst) begin
      m_st = 0; tag = "R1";
    end else begin
      case (m_st)
        0: begin
          tag = (!cmp_en && !lock_cmp) ? "R3" : "R4";
          if (pin_ok && (ext_mode || (lock_det_en && lock_ok))) m_st = 1;
        end
        1: begin
          if (!en) tag = "R2";
          else if (ext_mode) begin
            tag = "R8";
            if (ext_req) m_st = 2;
          end else if (!lock_det_en) tag = "R6";
          else begin
            tag = (swo_busy && ref_edge) ? "R7" : "R5";
            if (!lock_ok && pfd_tick && (!ref_edge || swo_busy)) m_st = 2;
          end
        end
        2: begin
          if (!en) begin tag = "R10"; m_st = 3; end
          else if (ext_mode) begin tag = "R8"; if (!ext_req) m_st = 3; end
          else begin tag = "R7"; if (evt) m_st = 3; end
        end
        default: begin
          tag = "R9";
          if (evt) begin m_st = 0; exp_br = 1'b1; end
        end
      endcase
    end
    exp_cp = (m_st == 2) || (m_st == 3);
  endtask

  task automatic cyc();
    @(posedge clk);
    model_step();
    @(negedge clk);
    checks++;
    if (cp_hiz !== exp_cp || fb_rst !== exp_br) begin
      failures++;
      $display("FAIL %s t=%0t cp_hiz=%0b exp=%0b fb_div_rst=%0b exp=%0b",
               tag, $time, cp_hiz, exp_cp, fb_rst, exp_br);
    end
  endtask

  task automatic tick(input bit edge_present);
    pfd_tick = 1'b1; ref_edge = edge_present; cyc();
    pfd_tick = 1'b0; ref_edge = 1'b0; cyc();
  endtask

  initial begin
    repeat (3) cyc();                       // R1 reset state
    rst = 1'b0;
    // R4: comparator low blocks arming, then arm
    lock_ok = 1'b1; repeat (3) cyc();
    lock_cmp = 1'b1; cyc();
    // R5: lock lost, tick with edge does nothing, tick without edge enters
    lock_ok = 1'b0; tick(1'b1); tick(1'b0);
    cyc();
    tick(1'b1);                             // leave to alignment
    repeat (2) cyc();
    tick(1'b1);                             // R9 release with B reset
    // R3: comparator disabled, pin low
    lock_cmp = 1'b0; cmp_en = 1'b0; lock_ok = 1'b1; repeat (2) cyc();
    // R2: one enable cleared
    en_b = 1'b0; lock_ok = 1'b0; tick(1'b0); tick(1'b0);
    en_b = 1'b1;
    // R6: lock detect disabled
    lock_det_en = 1'b0; tick(1'b0); tick(1'b0);
    lock_det_en = 1'b1;
    // R7: switchover with lock lost, edge present
    swo_busy = 1'b1; tick(1'b1); swo_busy = 1'b0;
    cyc(); tick(1'b1); tick(1'b1);
    // R8: external request and release
    ext_mode = 1'b1; cyc();
    ext_req = 1'b1; repeat (3) cyc();
    ext_req = 1'b0; repeat (2) cyc();
    tick(1'b1);
    repeat (2) cyc();
    // R10: disable during holdover
    ext_req = 1'b1; repeat (2) cyc();
    en_a = 1'b0; repeat (2) cyc();
    tick(1'b0); tick(1'b1);
    en_a = 1'b1; ext_req = 1'b0; ext_mode = 1'b0; cmp_en = 1'b1; lock_cmp = 1'b1;
    // random phase
    for (int i = 0; i < 6000; i++) begin
      if (i % 97 == 0) begin
        ext_mode    = ($urandom_range(0, 3) == 0);
        cmp_en      = $urandom_range(0, 1);
        lock_det_en = ($urandom_range(0, 7) != 0);
        en_a        = ($urandom_range(0, 7) != 0);
        en_b        = ($urandom_range(0, 7) != 0);
      end
      if (i % 13 == 0) lock_ok = ($urandom_range(0, 2) != 0);
      if (i % 29 == 0) ext_req = ($urandom_range(0, 2) == 0);
      lock_cmp = ($urandom_range(0, 4) != 0);
      pfd_tick = ($urandom_range(0, 2) == 0);
      ref_edge = ($urandom_range(0, 3) != 0);
      swo_busy = ($urandom_range(0, 9) == 0);
      rst      = (i == 3000);
      cyc();
    end
    rst = 1'b0;
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule